// File: doc/BRIEF.md
# Shared Bus Arbiter with Lock and Interrupt Clear

This block decides which master may next drive a shared bus. One external processor and a parameterised set of internal DMA channels each present a request and receive a grant. Every master shares one bus-busy line. The arbiter never takes the bus away from its owner. It hands out a grant only while bus-busy is released. It withdraws the grant as soon as the new owner raises bus-busy.

Internal channels outrank the external processor, and among them the lowest index wins. The external processor can hold the bus through a locked sequence. It does this with an active-low lock input, which stops any internal channel from being granted in between. A clear input, or an interrupt-pending indication that is latched until an end-of-interrupt pulse, masks internal requests and raises a yield output. The yield output tells the internal channels to release the bus, so the processor can get in.

Top module: `bus_arbiter_lock`

## Requirements
- R1: After reset all grants are low and `dma_yield` is low. No owner is recorded, so `lock_n` low does not block an internal channel.
- R2: Grants are registered. A grant reflects the request and busy state sampled at the previous rising edge. After any edge at which `bus_busy` was high, every grant is low.
- R3: At most one grant (processor or any channel) is high at any time.
- R4: When the bus is free and at least one unmasked channel requests, the processor is not granted, even if it requests.
- R5: Among requesting channels, the one with the lowest index is granted.
- R6: When only the processor requests on a free bus, `cpu_gnt` goes high one edge later.
- R7: The owner is the master whose grant was high at the edge where `bus_busy` was first seen high. If that owner is the processor and `lock_n` is low, no channel is granted, and the processor is granted again if it requests.
- R8: If the recorded owner is a channel, `lock_n` low has no effect on arbitration.
- R9: While `clr_in` is high, `dma_yield` is high in the same cycle and no channel is granted. The processor may still be granted.
- R10: A rising `irq_pend` sets an interrupt latch at the next edge, which drives `dma_yield` high and masks channels. The latch stays set after `irq_pend` falls and clears at the edge that samples `irq_eoi` high (this applies when `IRQ_CLEAR_EN` is 1, the default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | External processor bus request, active high |
| cpu_gnt | output | 1 | External processor bus grant, active high |
| dma_req | input | N_DMA | Internal channel requests, bit i is channel i |
| dma_gnt | output | N_DMA | Internal channel grants, bit i is channel i |
| bus_busy | input | 1 | Shared bus-busy, high while any master owns the bus |
| lock_n | input | 1 | Processor lock, active low, idle high |
| clr_in | input | 1 | Force internal channels off the bus, active high |
| irq_pend | input | 1 | Interrupt pending from the processor side, active high |
| irq_eoi | input | 1 | End-of-interrupt pulse that clears the latch |
| dma_yield | output | 1 | Request to internal channels to release the bus |

## Verification
Grants come out one rising edge after the edge that samples requests, busy, lock and the masks. The owner record and the interrupt latch also change one edge after their triggers, so a lock or interrupt effect shows on the grants two edges after the stimulus. `dma_yield` follows `clr_in` within the same cycle. The bench changes inputs one time unit after a rising edge and reads outputs one time unit after the next rising edge. Every check therefore lands exactly on the cycle in which each result is due.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_DMA  = 2'd2
  } own_kind_e;

  // Owner after a bus-busy take: the holder of the registered grant.
  function automatic own_kind_e next_owner(input logic take,
                                           input logic had_cpu_gnt,
                                           input logic had_dma_gnt,
                                           input own_kind_e prev);
    if (!take)           return prev;
    else if (had_cpu_gnt) return OWN_CPU;
    else if (had_dma_gnt) return OWN_DMA;
    else                  return prev;
  endfunction

  // Channel requests that survive the lock and yield masks.
  function automatic logic mask_open(input logic lock_hold, input logic yield_on);
    return !(lock_hold || yield_on);
  endfunction

endpackage

// File: rtl/arb_fixed_prio.sv
module arb_fixed_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_ch
    assign pick[i]     = req[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | req[i];
  end

  assign any = seen[N];
endmodule

// File: rtl/arb_irq_latch.sv
module arb_irq_latch #(
  parameter bit ENABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend,
  input  logic eoi,
  output logic latched,
  output logic set_evt
);
  if (ENABLE) begin : g_on
    logic pend_q;
    logic lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        lat_q  <= 1'b0;
      end else begin
        pend_q <= pend;
        if (set_evt)  lat_q <= 1'b1;
        else if (eoi) lat_q <= 1'b0;
      end
    end
    assign set_evt = pend & ~pend_q;
    assign latched = lat_q;
  end else begin : g_off
    assign set_evt = 1'b0;
    assign latched = 1'b0;
  end
endmodule

// File: rtl/arb_owner_track.sv
module arb_owner_track
  import arb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bus_busy,
  input  logic      had_cpu_gnt,
  input  logic      had_dma_gnt,
  output own_kind_e kind,
  output logic      take_evt
);
  logic busy_q;

  assign take_evt = bus_busy & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind   <= OWN_NONE;
    end else begin
      busy_q <= bus_busy;
      kind   <= next_owner(take_evt, had_cpu_gnt, had_dma_gnt, kind);
    end
  end
endmodule

// File: rtl/bus_arbiter_lock.sv
module bus_arbiter_lock
  import arb_pkg::*;
#(
  parameter int N_DMA        = 4,
  parameter bit IRQ_CLEAR_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  output logic             cpu_gnt,
  input  logic [N_DMA-1:0] dma_req,
  output logic [N_DMA-1:0] dma_gnt,
  input  logic             bus_busy,
  input  logic             lock_n,
  input  logic             clr_in,
  input  logic             irq_pend,
  input  logic             irq_eoi,
  output logic             dma_yield
);
  own_kind_e        owner_kind;
  logic             take_evt;
  logic             irq_lat;
  logic             irq_set_evt;
  logic             lock_hold;
  logic             dma_block;
  logic [N_DMA-1:0] dma_open;
  logic [N_DMA-1:0] dma_pick;
  logic             dma_any;
  logic             cpu_win;
  logic             cpu_gnt_q;
  logic [N_DMA-1:0] dma_gnt_q;

  arb_irq_latch #(.ENABLE(IRQ_CLEAR_EN)) u_irq (
    .clk(clk), .rst_n(rst_n), .pend(irq_pend), .eoi(irq_eoi),
    .latched(irq_lat), .set_evt(irq_set_evt)
  );

  arb_owner_track u_own (
    .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy),
    .had_cpu_gnt(cpu_gnt_q), .had_dma_gnt(|dma_gnt_q),
    .kind(owner_kind), .take_evt(take_evt)
  );

  assign dma_yield = clr_in | irq_lat;
  assign lock_hold = ~lock_n & (owner_kind == OWN_CPU);
  assign dma_block = ~mask_open(lock_hold, dma_yield);
  assign dma_open  = dma_block ? '0 : dma_req;

  arb_fixed_prio #(.N(N_DMA)) u_prio (
    .req(dma_open), .pick(dma_pick), .any(dma_any)
  );

  assign cpu_win = cpu_req & ~dma_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_gnt_q <= 1'b0;
      dma_gnt_q <= '0;
    end else if (bus_busy) begin
      cpu_gnt_q <= 1'b0;
      dma_gnt_q <= '0;
    end else begin
      cpu_gnt_q <= cpu_win;
      dma_gnt_q <= dma_pick;
    end
  end

  assign cpu_gnt = cpu_gnt_q;
  assign dma_gnt = dma_gnt_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int N_DMA = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_busy,
  input logic             clr_in,
  input logic [N_DMA-1:0] dma_req,
  input logic             cpu_gnt,
  input logic [N_DMA-1:0] dma_gnt,
  input logic             dma_yield,
  input logic             lock_hold,
  input logic             dma_block,
  input logic             irq_set_evt
);
  assert_one_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_gnt, dma_gnt}));

  assert_busy_drops_grants_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> (!cpu_gnt && dma_gnt == '0));

  assert_lock_blocks_dma_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hold |=> (dma_gnt == '0));

  assert_clear_blocks_dma_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_in |=> (dma_gnt == '0));

  assert_irq_sets_yield_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set_evt |=> dma_yield);

  assert_dma_beats_cpu_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy && dma_req != '0 && !dma_block) |=> !cpu_gnt);

  assert_low_index_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_busy && dma_req[0] && !dma_block) |=> dma_gnt[0]);
endmodule

bind bus_arbiter_lock arb_checker #(.N_DMA(N_DMA)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .clr_in(clr_in),
  .dma_req(dma_req), .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt),
  .dma_yield(dma_yield), .lock_hold(lock_hold), .dma_block(dma_block),
  .irq_set_evt(irq_set_evt)
);

// File: tb/tb_bus_arbiter_lock.sv
module tb_bus_arbiter_lock;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cpu_req = 1'b0;
  logic         cpu_gnt;
  logic [N-1:0] dma_req = '0;
  logic [N-1:0] dma_gnt;
  logic         bus_busy = 1'b0;
  logic         lock_n = 1'b1;
  logic         clr_in = 1'b0;
  logic         irq_pend = 1'b0;
  logic         irq_eoi = 1'b0;
  logic         dma_yield;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bus_arbiter_lock #(.N_DMA(N)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_gnt(cpu_gnt),
    .dma_req(dma_req), .dma_gnt(dma_gnt), .bus_busy(bus_busy),
    .lock_n(lock_n), .clr_in(clr_in), .irq_pend(irq_pend),
    .irq_eoi(irq_eoi), .dma_yield(dma_yield)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check_gnt(input logic exp_cpu, input logic [N-1:0] exp_dma, input string tag);
    checks++;
    if (cpu_gnt !== exp_cpu || dma_gnt !== exp_dma) begin
      fails++;
      $display("FAIL %s: cpu_gnt=%b dma_gnt=%b expected cpu_gnt=%b dma_gnt=%b",
               tag, cpu_gnt, dma_gnt, exp_cpu, exp_dma);
    end
    checks++;
    if ($countones({cpu_gnt, dma_gnt}) > 1) begin
      fails++;
      $display("FAIL R3: grants=%b expected at most one high", {cpu_gnt, dma_gnt});
    end
  endtask

  task automatic check_yield(input logic exp, input string tag);
    checks++;
    if (dma_yield !== exp) begin
      fails++;
      $display("FAIL %s: dma_yield=%b expected %b", tag, dma_yield, exp);
    end
  endtask

  task automatic idle();
    cpu_req = 1'b0; dma_req = '0; bus_busy = 1'b0;
    lock_n = 1'b1; clr_in = 1'b0; irq_pend = 1'b0; irq_eoi = 1'b0;
    step();
  endtask

  // R1: reset state, and lock ignored with no owner recorded
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) step();
    check_gnt(1'b0, 4'b0000, "R1 grants in reset");
    check_yield(1'b0, "R1 yield in reset");
    rst_n = 1'b1;
    step();
    check_gnt(1'b0, 4'b0000, "R1 grants after reset");
    lock_n = 1'b0; dma_req = 4'b0010;
    step();
    check_gnt(1'b0, 4'b0010, "R1 no owner, lock ignored");
    idle();
  endtask

  // R6, R2, R7, R11-style owner capture, R4
  task automatic t_cpu_lock();
    cpu_req = 1'b1;
    step();
    check_gnt(1'b1, 4'b0000, "R6 lone cpu request");
    bus_busy = 1'b1;
    step();
    check_gnt(1'b0, 4'b0000, "R2 grant withdrawn on busy");
    dma_req = 4'b0001;
    step();
    check_gnt(1'b0, 4'b0000, "R2 no grant while busy");
    bus_busy = 1'b0; lock_n = 1'b0;
    step();
    check_gnt(1'b1, 4'b0000, "R7 locked cpu regranted over dma");
    lock_n = 1'b1;
    step();
    check_gnt(1'b0, 4'b0001, "R4 dma outranks cpu");
  endtask

  // R5 and R8: priority order, lock ignored when a channel owns
  task automatic t_prio_lock_dma();
    dma_req = 4'b1010; cpu_req = 1'b1;
    step();
    check_gnt(1'b0, 4'b0010, "R5 lowest index wins");
    bus_busy = 1'b1;
    step();
    bus_busy = 1'b0; lock_n = 1'b0; dma_req = 4'b1100;
    step();
    check_gnt(1'b0, 4'b0100, "R8 lock ignored for dma owner");
    dma_req = 4'b1000;
    step();
    check_gnt(1'b0, 4'b1000, "R5 highest channel alone");
    idle();
  endtask

  // R9: clear masks channels and raises yield combinationally
  task automatic t_clear();
    clr_in = 1'b1; dma_req = 4'b0001; cpu_req = 1'b1;
    #1;
    check_yield(1'b1, "R9 yield follows clear");
    step();
    check_gnt(1'b1, 4'b0000, "R9 cpu granted under clear");
    cpu_req = 1'b0;
    step();
    check_gnt(1'b0, 4'b0000, "R9 dma masked by clear");
    clr_in = 1'b0;
    #1;
    check_yield(1'b0, "R9 yield drops with clear");
    step();
    check_gnt(1'b0, 4'b0001, "R9 dma back after clear");
    idle();
  endtask

  // R10: latched interrupt clear until end-of-interrupt
  task automatic t_irq();
    irq_pend = 1'b1;
    step();
    check_yield(1'b1, "R10 latch set on pend rise");
    irq_pend = 1'b0; dma_req = 4'b0100;
    step();
    check_gnt(1'b0, 4'b0000, "R10 dma masked after pend falls");
    step();
    check_yield(1'b1, "R10 latch holds");
    irq_eoi = 1'b1;
    step();
    irq_eoi = 1'b0;
    check_yield(1'b0, "R10 latch cleared by eoi");
    step();
    check_gnt(1'b0, 4'b0100, "R10 dma granted after eoi");
    idle();
  endtask

  initial begin
    t_reset();
    t_cpu_lock();
    t_prio_lock_dma();
    t_clear();
    t_irq();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule